// File: doc/BRIEF.md
# Variable-Group Carry-Select Adder

This block adds two unsigned WIDTH-bit operands and a carry input, producing a WIDTH-bit sum and a carry output. The operand bits are cut into consecutive groups. The lowest group is a single ripple adder fed by the true carry input. Every higher group runs two ripple adders side by side, one assuming its incoming carry is 0 and one assuming it is 1. Both candidate results are ready early. A chain of two-way multiplexers then walks upward and picks one candidate per group as each real group carry becomes known. The carry is never rippled through a group a second time.

Group widths are not uniform. They grow from the least significant end, so that the ripple time inside a group roughly equals the time the select chain needs to deliver that group's carry. With the default list (4, 4, 5, 6, 6, 7 bits, lowest group first), each group's candidates settle at about the moment its select input arrives. The width list is a parameter. Its sum must equal WIDTH, and elaboration stops with an error if it does not. The sum and carry are registered once, with a synchronous active-high reset, so a result appears on the clock edge after its operands are presented.

Top module: `varcsel_adder`

## Requirements
- R1: On every clock edge with `rst` low, `{cout, sum}` takes the value `a + b + cin` of the operands present at that edge. The latency is exactly one cycle.
- R2: On a clock edge with `rst` high, `sum` and `cout` become all zeros, whatever the operands are.
- R3: The carry selected at every group boundary (bit positions 4, 8, 13, 19 and 25 by default) equals the true carry into that bit position. Operands of the form (2^k − 1) + 1 at each boundary k therefore give a sum of exactly 2^k.
- R4: In every group above the lowest, the candidate built for incoming carry 1 equals the candidate for incoming carry 0 plus one, carry output included. Arbitrary operands with either carry input value produce the correct sum.
- R5: The lowest group adds with the real `cin` and both of its candidate views are identical. `0 + 0 + cin=1` yields `sum = 1`, `cout = 0`.
- R6: `cout` is the selected outgoing carry of the most significant group. For example, `0x80000000 + 0x80000000` gives `sum = 0`, `cout = 1`.
- R7: Alternating-bit operands `0xAAAAAAAA + 0x55555555` give all ones with `cout = 0` when `cin = 0`. They give `sum = 0`, `cout = 1` when `cin = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry input |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry output |

## Verification
The first group of patterns carries a 1 across each group boundary: operands of the form 2^k − 1 plus one, and all ones plus the carry input. These show whether each multiplexer takes its select from the right, already-resolved carry. Alternating-bit operands make every bit propagate without generating. With the carry input flipped, they separate a correct end-to-end select chain from one that drops the carry somewhere in the middle. Operands with the top bit set isolate the carry-out path. A random sweep covers both candidate paths of every group. A reset applied mid-run confirms that the registered outputs clear regardless of the operands.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int MAX_GROUPS = 32;
  localparam int WFIELD     = 8;
  typedef logic [MAX_GROUPS*WFIELD-1:0] width_list_t;

  function automatic int grp_width(width_list_t lst, int g);
    return int'(lst[g*WFIELD +: WFIELD]);
  endfunction

  function automatic int grp_base(width_list_t lst, int g);
    int acc;
    acc = 0;
    for (int j = 0; j < g; j++) acc += int'(lst[j*WFIELD +: WFIELD]);
    return acc;
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p      = a[i] ^ b[i];
    assign s[i]   = p ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
  end
  assign co = c[W];
endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum0,
  output logic         cout0,
  output logic [W-1:0] sum1,
  output logic         cout1
);
  csel_ripple #(.W(W)) u_zero (.a(a), .b(b), .ci(1'b0), .s(sum0), .co(cout0));
  csel_ripple #(.W(W)) u_one  (.a(a), .b(b), .ci(1'b1), .s(sum1), .co(cout1));
endmodule

// File: rtl/csel_mux.sv
module csel_mux #(
  parameter int W = 5
) (
  input  logic         sel,
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  output logic [W-1:0] y
);
  assign y = sel ? in1 : in0;
endmodule

// File: rtl/varcsel_adder.sv
module varcsel_adder #(
  parameter int WIDTH      = 32,
  parameter int NUM_GROUPS = 6,
  parameter csel_pkg::width_list_t GROUP_W =
    csel_pkg::width_list_t'({8'd7, 8'd6, 8'd6, 8'd5, 8'd4, 8'd4})
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int TOTAL = csel_pkg::grp_base(GROUP_W, NUM_GROUPS);
  localparam int W0    = csel_pkg::grp_width(GROUP_W, 0);

  if (TOTAL != WIDTH) begin : g_bad_widths
    $error("group width list does not add up to WIDTH");
  end

  logic [WIDTH-1:0]    cand0_sum, cand1_sum, next_sum;
  logic [NUM_GROUPS-1:0] cand0_cout, cand1_cout;
  logic [NUM_GROUPS:0]   grp_carry;

  assign grp_carry[0] = cin;

  // lowest group: single ripple on the true carry input
  csel_ripple #(.W(W0)) u_grp0 (
    .a(a[W0-1:0]), .b(b[W0-1:0]), .ci(cin),
    .s(cand0_sum[W0-1:0]), .co(cand0_cout[0])
  );
  assign cand1_sum[W0-1:0] = cand0_sum[W0-1:0];
  assign cand1_cout[0]     = cand0_cout[0];
  assign next_sum[W0-1:0]  = cand0_sum[W0-1:0];
  assign grp_carry[1]      = cand0_cout[0];

  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_upper
    localparam int GW   = csel_pkg::grp_width(GROUP_W, g);
    localparam int BASE = csel_pkg::grp_base(GROUP_W, g);
    logic [GW:0] picked;

    csel_group #(.W(GW)) u_grp (
      .a(a[BASE +: GW]), .b(b[BASE +: GW]),
      .sum0(cand0_sum[BASE +: GW]), .cout0(cand0_cout[g]),
      .sum1(cand1_sum[BASE +: GW]), .cout1(cand1_cout[g])
    );

    csel_mux #(.W(GW+1)) u_sel (
      .sel(grp_carry[g]),
      .in0({cand0_cout[g], cand0_sum[BASE +: GW]}),
      .in1({cand1_cout[g], cand1_sum[BASE +: GW]}),
      .y(picked)
    );

    assign next_sum[BASE +: GW] = picked[GW-1:0];
    assign grp_carry[g+1]       = picked[GW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= next_sum;
      cout <= grp_carry[NUM_GROUPS];
    end
  end
endmodule

// File: rtl/varcsel_adder_chk.sv
module varcsel_adder_chk #(
  parameter int WIDTH      = 32,
  parameter int NUM_GROUPS = 6,
  parameter csel_pkg::width_list_t GROUP_W = '0
) (
  input logic                  clk,
  input logic                  rst,
  input logic [WIDTH-1:0]      a,
  input logic [WIDTH-1:0]      b,
  input logic                  cin,
  input logic [WIDTH-1:0]      sum,
  input logic                  cout,
  input logic [NUM_GROUPS:0]   grp_carry,
  input logic [WIDTH-1:0]      cand0_sum,
  input logic [WIDTH-1:0]      cand1_sum,
  input logic [NUM_GROUPS-1:0] cand0_cout,
  input logic [NUM_GROUPS-1:0] cand1_cout
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  // R1: registered result equals previous-cycle operands' sum
  p_result_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> {cout, sum} == $past(ref_total));

  // R2: reset clears outputs
  p_reset_clear_r2: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && cout == 1'b0));

  // R5: lowest group has identical candidate views and uses the real carry in
  p_low_group_r5: assert property (@(posedge clk) disable iff (rst)
    cand0_sum[csel_pkg::grp_width(GROUP_W, 0)-1:0] ==
    cand1_sum[csel_pkg::grp_width(GROUP_W, 0)-1:0] && grp_carry[0] == cin);

  // R6: carry out follows top group's selected carry
  p_cout_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cout == $past(grp_carry[NUM_GROUPS]));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    localparam int GW  = csel_pkg::grp_width(GROUP_W, g);
    localparam int BASE = csel_pkg::grp_base(GROUP_W, g);
    localparam int TOP  = BASE + GW;
    localparam logic [WIDTH:0] MASK = {{(WIDTH+1-TOP){1'b0}}, {TOP{1'b1}}};
    logic [WIDTH:0] low_total;
    assign low_total = ({1'b0, a} & MASK) + ({1'b0, b} & MASK) + {{WIDTH{1'b0}}, cin};

    // R3: every selected boundary carry is the true carry
    p_group_carry_r3: assert property (@(posedge clk) disable iff (rst)
      grp_carry[g+1] == low_total[TOP]);

    if (g > 0) begin : g_pair
      // R4: carry-1 candidate is carry-0 candidate plus one
      p_cand_pair_r4: assert property (@(posedge clk) disable iff (rst)
        {cand1_cout[g], cand1_sum[BASE +: GW]} ==
        (GW+1)'({cand0_cout[g], cand0_sum[BASE +: GW]} + (GW+1)'(1)));
    end
  end
endmodule

bind varcsel_adder varcsel_adder_chk #(
  .WIDTH(WIDTH), .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)
) u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
  .grp_carry(grp_carry), .cand0_sum(cand0_sum), .cand1_sum(cand1_sum),
  .cand0_cout(cand0_cout), .cand1_cout(cand1_cout)
);

// File: tb/varcsel_adder_bench.sv
`timescale 1ns/1ps
module varcsel_adder_bench;
  localparam int WIDTH = 32;
  localparam int NVEC  = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] a = '0, b = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] sum;
  logic             cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  varcsel_adder u_varcsel_adder (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  // entry: {requirement number[7:0], cin, a, b}
  localparam logic [72:0] VEC [NVEC] = '{
    {8'd1, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R1 zeros
    {8'd1, 1'b0, 32'h1234_5678, 32'h8765_4321},  // R1 mixed
    {8'd5, 1'b1, 32'h0000_0000, 32'h0000_0000},  // R5 carry in only
    {8'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},  // R3 full propagate
    {8'd3, 1'b0, 32'h0000_000F, 32'h0000_0001},  // R3 boundary 4
    {8'd3, 1'b0, 32'h0000_00FF, 32'h0000_0001},  // R3 boundary 8
    {8'd3, 1'b0, 32'h0000_1FFF, 32'h0000_0001},  // R3 boundary 13
    {8'd3, 1'b0, 32'h0007_FFFF, 32'h0000_0001},  // R3 boundary 19
    {8'd3, 1'b0, 32'h01FF_FFFF, 32'h0000_0001},  // R3 boundary 25
    {8'd7, 1'b0, 32'hAAAA_AAAA, 32'h5555_5555},  // R7 alternating
    {8'd7, 1'b1, 32'hAAAA_AAAA, 32'h5555_5555},  // R7 alternating + cin
    {8'd6, 1'b0, 32'h8000_0000, 32'h8000_0000},  // R6 top carry
    {8'd6, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}   // R6 all ones
  };

  task automatic check(input string req, input logic [WIDTH:0] got,
                       input logic [WIDTH:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
               req, got[WIDTH], got[WIDTH-1:0], exp[WIDTH], exp[WIDTH-1:0]);
    end
  endtask

  task automatic apply(input string req, input logic [WIDTH-1:0] va,
                       input logic [WIDTH-1:0] vb, input logic vc);
    logic [WIDTH:0] exp;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    exp = {1'b0, va} + {1'b0, vb} + {{WIDTH{1'b0}}, vc};
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  initial begin
    // R2: outputs clear under reset
    repeat (3) @(negedge clk);
    check("R2", {cout, sum}, '0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      apply($sformatf("R%0d", int'(VEC[i][72:65])),
            VEC[i][63:32], VEC[i][31:0], VEC[i][64]);
    end

    // R4: random operands with both carry values exercise both candidates
    for (int i = 0; i < 300; i++) begin
      apply("R4", $urandom, $urandom, 1'($urandom));
    end

    // R1: one-cycle latency, result tracks back-to-back operands
    apply("R1", 32'hDEAD_BEEF, 32'h0101_0101, 1'b1);

    // R2: reset mid-run with operands that would set every output bit
    @(negedge clk);
    a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R2", {cout, sum}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {cout, sum}, {1'b1, 32'hFFFF_FFFF});

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule